// File: doc/BRIEF.md
# Register-Indirect Execute Unit

This block is the execute stage of a small 32-bit processor. Each cycle it may take one instruction word of the register-to-register class. It works on an eight-entry file of 32-bit registers, three condition flags and a 24-bit stack pointer. It reaches data memory through a simple word port. It carries out five arithmetic and shift operations, halt, push and pop, and two 32-bit moves that take their memory address from a register.

An address taken from a register is cut to its low 24 bits before it reaches the memory port. A store whose full address register holds 0x00FFFFFC also pulses a terminal-write strobe that carries the stored word. This gives software a character output without any other device logic. Loads and pops hold the unit busy until memory answers with a one-cycle read-valid pulse. Every other instruction completes in the cycle it is accepted.

Top module: `ind_exec_unit`

## Requirements
- R1: An instruction is accepted when `instr_valid` is high and neither `busy` nor `halted` is high. The word is decoded as follows: bits 31:29 must be 001; bits 28:16 are the opcode; bits 15:8 name operand A and bits 7:0 name operand B. Only the low three bits of each operand field select a register.
- R2: Opcode 0 (add) writes A+B into register A, and carry becomes the adder carry-out. Opcode 1 (subtract) writes A−B into register A, and carry becomes the borrow (1 when A < B unsigned).
- R3: Opcode 2 shifts register A left by one place and opcode 3 shifts it right by one place (logical). The result goes back into register A, and carry takes the bit shifted out.
- R4: Opcode 4 (compare) sets the flags exactly as subtract does and leaves register A unchanged.
- R5: After opcodes 0 to 4, the zero flag is set when the result is all zeros and the negative flag equals result bit 31. Opcodes 5 to 9, illegal words and ignored words leave all three flags unchanged.
- R6: Opcode 8 puts register A on `mem_wdata` with `mem_req` and `mem_we` high in the same cycle. The address is the low 24 bits of register B.
- R7: Opcode 9 raises `mem_req` with `mem_we` low, at the low 24 bits of register A. `busy` is then high from the next cycle until the cycle in which `mem_rvalid` is seen. In that cycle `mem_rdata` is written into register B. Words offered while busy are ignored.
- R8: A store whose address register holds exactly 0x00FFFFFC raises `term_strobe` in the same cycle, with `term_data` equal to the stored word. An address register of 0x01FFFFFC reaches memory as 0xFFFFFC but raises no strobe.
- R9: The stack pointer resets to 0xFFFFF0. Opcode 6 (push) writes register A at the stack pointer minus 4 and leaves the pointer at that value.
- R10: Opcode 7 (pop) reads at the current stack pointer and waits for `mem_rvalid` as in R7. It then writes the returned word into register A, and the pointer grows by 4.
- R11: A word whose top bits are not 001, or whose opcode is above 9, raises `illegal_op` in that cycle. It makes no memory request and changes no state.
- R12: Opcode 5 sets `halted` from the next cycle until reset. A halted unit ignores all words and makes no memory request.
- R13: Reset clears every register and all flags and leaves the unit neither busy nor halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word offered this cycle |
| instr_word | input | 32 | Instruction word |
| busy | output | 1 | Waiting for read data |
| halted | output | 1 | Halt executed |
| illegal_op | output | 1 | Offered word was accepted but not recognised |
| flag_zero | output | 1 | Zero flag |
| flag_carry | output | 1 | Carry / borrow / shifted-out bit |
| flag_neg | output | 1 | Negative flag |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 24 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |
| mem_rvalid | input | 1 | Read data valid pulse |
| term_strobe | output | 1 | Terminal write strobe |
| term_data | output | 32 | Word written to the terminal |

## Verification
The bench drives several kinds of operand through the arithmetic path. The adder case has carry-out and a sign flip, the subtract case borrows, and shift left moves a one out of bit 31. A unit that took carry from the wrong bit, or that let compare write its register back, would then disagree with the model on the flags or on a later store of that register. The bench stores through 0x00FFFFFC and through 0x01FFFFFC: a design that compared the masked address would strobe on both, and one that did not mask would place the second address wrong. Loads and pops are answered after different delays, with words offered in between. A design that accepted those words, or that wrote the wrong destination, shows up on the next store. Illegal words, the stack pointer sequence and the words offered after halt complete the set.

// File: rtl/ind_exec_pkg.sv
package ind_exec_pkg;
  localparam int unsigned OPC_W = 13;

  typedef enum logic [3:0] {
    K_ADD, K_SUB, K_SHL, K_SHR, K_CMP,
    K_HALT, K_PUSH, K_POP, K_STORE, K_LOAD, K_BAD
  } kind_e;

  typedef enum logic [1:0] {
    A_ADD, A_SUB, A_SHL, A_SHR
  } alu_fn_e;
endpackage

// File: rtl/ind_exec_decode.sv
module ind_exec_decode
  import ind_exec_pkg::*;
#(
  parameter int unsigned IW = 3
) (
  input  logic [31:0]   word,
  output kind_e         kind,
  output logic [IW-1:0] idx_a,
  output logic [IW-1:0] idx_b
);
  logic [OPC_W-1:0] opc;

  assign opc   = word[28:16];
  assign idx_a = word[8 +: IW];
  assign idx_b = word[0 +: IW];

  always_comb begin
    kind = K_BAD;
    if (word[31:29] == 3'b001) begin
      case (opc)
        13'd0:   kind = K_ADD;
        13'd1:   kind = K_SUB;
        13'd2:   kind = K_SHL;
        13'd3:   kind = K_SHR;
        13'd4:   kind = K_CMP;
        13'd5:   kind = K_HALT;
        13'd6:   kind = K_PUSH;
        13'd7:   kind = K_POP;
        13'd8:   kind = K_STORE;
        13'd9:   kind = K_LOAD;
        default: kind = K_BAD;
      endcase
    end
  end
endmodule

// File: rtl/ind_exec_regfile.sv
module ind_exec_regfile #(
  parameter int unsigned NREG = 8,
  parameter int unsigned DW   = 32,
  localparam int unsigned IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_a_idx,
  input  logic [IW-1:0] rd_b_idx,
  output logic [DW-1:0] rd_a_data,
  output logic [DW-1:0] rd_b_data,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data
);
  logic [DW-1:0] cells [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_cell
    logic cell_en;
    assign cell_en = wr_en && (wr_idx == IW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cells[i] <= '0;
      end else if (cell_en) begin
        cells[i] <= wr_data;
      end
    end
  end

  assign rd_a_data = cells[rd_a_idx];
  assign rd_b_data = cells[rd_b_idx];
endmodule

// File: rtl/ind_exec_alu.sv
module ind_exec_alu
  import ind_exec_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  alu_fn_e       fn,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  output logic [DW-1:0] res,
  output logic          cout
);
  logic [DW:0] wide;

  always_comb begin
    wide = '0;
    res  = '0;
    cout = 1'b0;
    case (fn)
      A_ADD: begin
        wide = {1'b0, opa} + {1'b0, opb};
        res  = wide[DW-1:0];
        cout = wide[DW];
      end
      A_SUB: begin
        wide = {1'b0, opa} - {1'b0, opb};
        res  = wide[DW-1:0];
        cout = wide[DW];
      end
      A_SHL: begin
        res  = {opa[DW-2:0], 1'b0};
        cout = opa[DW-1];
      end
      default: begin
        res  = {1'b0, opa[DW-1:1]};
        cout = opa[0];
      end
    endcase
  end
endmodule

// File: rtl/ind_exec_unit.sv
module ind_exec_unit
  import ind_exec_pkg::*;
#(
  parameter int unsigned  DW        = 32,
  parameter int unsigned  AW        = 24,
  parameter int unsigned  NREG      = 8,
  parameter int unsigned  SP_STEP   = 4,
  parameter logic [AW-1:0] SP_RESET = 24'hFFFFF0,
  parameter logic [DW-1:0] TERM_REG = 32'h00FFFFFC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_valid,
  input  logic [31:0]   instr_word,
  output logic          busy,
  output logic          halted,
  output logic          illegal_op,
  output logic          flag_zero,
  output logic          flag_carry,
  output logic          flag_neg,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_rvalid,
  output logic          term_strobe,
  output logic [DW-1:0] term_data
);
  localparam int unsigned IW = $clog2(NREG);

  kind_e         kind;
  logic [IW-1:0] idx_a, idx_b;
  logic [DW-1:0] val_a, val_b;
  logic [DW-1:0] alu_res;
  logic          alu_c;
  alu_fn_e       alu_fn;

  logic          accept;
  logic          rf_we;
  logic [IW-1:0] rf_widx;
  logic [DW-1:0] rf_wdata;

  logic          wait_q, wait_d;
  logic [IW-1:0] dst_q, dst_d;
  logic          halt_q, halt_d;
  logic [AW-1:0] sp_q, sp_d;
  logic          z_q, c_q, n_q;
  logic          z_d, c_d, n_d;
  logic          state_en;

  ind_exec_decode #(.IW(IW)) u_dec (
    .word  (instr_word),
    .kind  (kind),
    .idx_a (idx_a),
    .idx_b (idx_b)
  );

  ind_exec_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_a_idx  (idx_a),
    .rd_b_idx  (idx_b),
    .rd_a_data (val_a),
    .rd_b_data (val_b),
    .wr_en     (rf_we),
    .wr_idx    (rf_widx),
    .wr_data   (rf_wdata)
  );

  always_comb begin
    case (kind)
      K_ADD:   alu_fn = A_ADD;
      K_SHL:   alu_fn = A_SHL;
      K_SHR:   alu_fn = A_SHR;
      default: alu_fn = A_SUB;
    endcase
  end

  ind_exec_alu #(.DW(DW)) u_alu (
    .fn   (alu_fn),
    .opa  (val_a),
    .opb  (val_b),
    .res  (alu_res),
    .cout (alu_c)
  );

  assign accept = instr_valid && !halt_q && !wait_q;

  // next-state logic
  always_comb begin
    rf_we       = 1'b0;
    rf_widx     = idx_a;
    rf_wdata    = alu_res;
    wait_d      = wait_q;
    dst_d       = dst_q;
    halt_d      = halt_q;
    sp_d        = sp_q;
    z_d         = z_q;
    c_d         = c_q;
    n_d         = n_q;
    illegal_op  = 1'b0;
    mem_req     = 1'b0;
    mem_we      = 1'b0;
    mem_addr    = '0;
    mem_wdata   = '0;
    term_strobe = 1'b0;
    term_data   = '0;

    if (wait_q && mem_rvalid) begin
      rf_we    = 1'b1;
      rf_widx  = dst_q;
      rf_wdata = mem_rdata;
      wait_d   = 1'b0;
    end

    if (accept) begin
      case (kind)
        K_ADD, K_SUB, K_SHL, K_SHR, K_CMP: begin
          rf_we = (kind != K_CMP);
          z_d   = (alu_res == '0);
          c_d   = alu_c;
          n_d   = alu_res[DW-1];
        end
        K_HALT: halt_d = 1'b1;
        K_PUSH: begin
          sp_d      = sp_q - AW'(SP_STEP);
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = sp_d;
          mem_wdata = val_a;
        end
        K_POP: begin
          mem_req  = 1'b1;
          mem_addr = sp_q;
          sp_d     = sp_q + AW'(SP_STEP);
          wait_d   = 1'b1;
          dst_d    = idx_a;
        end
        K_STORE: begin
          mem_req     = 1'b1;
          mem_we      = 1'b1;
          mem_addr    = val_b[AW-1:0];
          mem_wdata   = val_a;
          term_strobe = (val_b == TERM_REG);
          term_data   = term_strobe ? val_a : '0;
        end
        K_LOAD: begin
          mem_req  = 1'b1;
          mem_addr = val_a[AW-1:0];
          wait_d   = 1'b1;
          dst_d    = idx_b;
        end
        default: illegal_op = 1'b1;
      endcase
    end
  end

  assign state_en = accept || wait_q;

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= 1'b0;
      dst_q  <= '0;
      halt_q <= 1'b0;
      sp_q   <= SP_RESET;
      z_q    <= 1'b0;
      c_q    <= 1'b0;
      n_q    <= 1'b0;
    end else if (state_en) begin
      wait_q <= wait_d;
      dst_q  <= dst_d;
      halt_q <= halt_d;
      sp_q   <= sp_d;
      z_q    <= z_d;
      c_q    <= c_d;
      n_q    <= n_d;
    end
  end

  assign busy       = wait_q;
  assign halted     = halt_q;
  assign flag_zero  = z_q;
  assign flag_carry = c_q;
  assign flag_neg   = n_q;
endmodule

// File: rtl/ind_exec_unit_chk.sv
module ind_exec_unit_chk #(
  parameter int unsigned   DW       = 32,
  parameter int unsigned   AW       = 24,
  parameter logic [DW-1:0] TERM_REG = 32'h00FFFFFC
) (
  input logic          clk,
  input logic          rst_n,
  input logic          instr_valid,
  input logic [31:0]   instr_word,
  input logic          busy,
  input logic          halted,
  input logic          illegal_op,
  input logic          flag_zero,
  input logic          flag_carry,
  input logic          flag_neg,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rvalid,
  input logic          term_strobe
);
  // R12: halt is sticky
  a_r12_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R12: no memory traffic or illegal report once halted
  a_r12_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_req && !illegal_op));

  // R11: an illegal word touches no memory
  a_r11_illegal_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> !mem_req);

  // R8: terminal strobe only with a write at the top word address
  a_r8_term_write: assert property (@(posedge clk) disable iff (!rst_n)
    term_strobe |-> (mem_req && mem_we && mem_addr == TERM_REG[AW-1:0]));

  // R7: a read request leaves the unit busy next cycle
  a_r7_read_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> busy);

  // R7: busy persists until read data arrives
  a_r7_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_rvalid) |=> busy);

  // R7: no new access while waiting
  a_r7_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !mem_req);

  // R5: flags move only after an accepted arithmetic word
  a_r5_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({flag_zero, flag_carry, flag_neg}) |->
      $past(instr_valid && !busy && !halted &&
            instr_word[31:29] == 3'b001 && instr_word[28:16] < 13'd5));
endmodule

bind ind_exec_unit ind_exec_unit_chk #(
  .DW(DW), .AW(AW), .TERM_REG(TERM_REG)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_valid (instr_valid),
  .instr_word  (instr_word),
  .busy        (busy),
  .halted      (halted),
  .illegal_op  (illegal_op),
  .flag_zero   (flag_zero),
  .flag_carry  (flag_carry),
  .flag_neg    (flag_neg),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .mem_rvalid  (mem_rvalid),
  .term_strobe (term_strobe)
);

// File: tb/ind_exec_unit_test.sv
module ind_exec_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_valid;
  logic [31:0] instr_word;
  logic        busy, halted, illegal_op;
  logic        flag_zero, flag_carry, flag_neg;
  logic        mem_req, mem_we;
  logic [23:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic        mem_rvalid;
  logic        term_strobe;
  logic [31:0] term_data;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;

  // reference state
  logic [31:0] m_reg [8];
  logic        m_z, m_c, m_n, m_halt, m_wait;
  logic [2:0]  m_dst;
  logic [23:0] m_sp;

  ind_exec_unit uut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
    .busy(busy), .halted(halted), .illegal_op(illegal_op),
    .flag_zero(flag_zero), .flag_carry(flag_carry), .flag_neg(flag_neg),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
    .term_strobe(term_strobe), .term_data(term_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] mk(input int opc, input int a, input int b);
    return 32'h2000_0000 | (32'(opc) << 16) | (32'(a) << 8) | 32'(b);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, got, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // One clock: drive, predict, compare, then advance the model.
  task automatic step(input logic v, input logic [31:0] w, input logic rv,
                      input logic [31:0] rd, input string req);
    logic acc, legal, e_ill, e_req, e_we, e_ts;
    logic [23:0] e_addr;
    logic [31:0] e_wd, ra, rb;
    logic [32:0] t;
    int opc;
    logic [2:0] a, b;
    logic [31:0] n_reg [8];
    logic nz, nc, nn, nh, nw;
    logic [2:0] nd;
    logic [23:0] nsp;
    @(negedge clk);
    instr_valid = v; instr_word = w; mem_rvalid = rv; mem_rdata = rd;
    #1;
    for (int i = 0; i < 8; i++) n_reg[i] = m_reg[i];
    nz = m_z; nc = m_c; nn = m_n; nh = m_halt; nw = m_wait; nd = m_dst; nsp = m_sp;
    acc = v && !m_halt && !m_wait;
    opc = int'(w[28:16]);
    a = w[10:8]; b = w[2:0];
    ra = m_reg[a]; rb = m_reg[b];
    legal = (w[31:29] == 3'b001) && (opc <= 9);
    e_ill = acc && !legal;
    e_req = 0; e_we = 0; e_addr = 0; e_wd = 0; e_ts = 0;
    if (m_wait && rv) begin n_reg[m_dst] = rd; nw = 0; end
    if (acc && legal) begin
      t = 33'd0;
      case (opc)
        0: t = {1'b0, ra} + {1'b0, rb};
        1: t = {1'b0, ra} - {1'b0, rb};
        2: t = {ra, 1'b0};
        3: t = {ra[0], 1'b0, ra[31:1]};
        4: t = {1'b0, ra} - {1'b0, rb};
        5: nh = 1;
        6: begin nsp = m_sp - 24'd4; e_req = 1; e_we = 1; e_addr = nsp; e_wd = ra; end
        7: begin e_req = 1; e_addr = m_sp; nsp = m_sp + 24'd4; nw = 1; nd = a; end
        8: begin e_req = 1; e_we = 1; e_addr = rb[23:0]; e_wd = ra;
                 e_ts = (rb == 32'h00FF_FFFC); end
        default: begin e_req = 1; e_addr = ra[23:0]; nw = 1; nd = b; end
      endcase
      if (opc <= 4) begin
        nc = t[32]; nz = (t[31:0] == 0); nn = t[31];
        if (opc != 4) n_reg[a] = t[31:0];
      end
    end
    chk(req, "illegal_op", 32'(illegal_op), 32'(e_ill));
    chk(req, "mem_req", 32'(mem_req), 32'(e_req));
    if (e_req) begin
      chk(req, "mem_we", 32'(mem_we), 32'(e_we));
      chk(req, "mem_addr", 32'(mem_addr), 32'(e_addr));
      if (e_we) chk(req, "mem_wdata", mem_wdata, e_wd);
    end
    chk(req, "term_strobe", 32'(term_strobe), 32'(e_ts));
    if (e_ts) chk(req, "term_data", term_data, e_wd);
    chk(req, "busy", 32'(busy), 32'(m_wait));
    chk(req, "halted", 32'(halted), 32'(m_halt));
    chk(req, "flags zcn", {29'd0, flag_zero, flag_carry, flag_neg}, {29'd0, m_z, m_c, m_n});
    @(posedge clk);
    for (int i = 0; i < 8; i++) m_reg[i] = n_reg[i];
    m_z = nz; m_c = nc; m_n = nn; m_halt = nh; m_wait = nw; m_dst = nd; m_sp = nsp;
  endtask

  task automatic idle(input string req);
    step(0, 32'h0, 0, 32'h0, req);
  endtask

  // Load or pop with a response after `gap` idle cycles; `junk` is offered while waiting.
  task automatic rd_op(input logic [31:0] w, input logic [31:0] data, input int gap,
                       input string req);
    step(1, w, 0, 32'h0, req);
    for (int i = 0; i < gap; i++) step(1, mk(8, 1, 0), 0, 32'h0, req);
    step(0, 32'h0, 1, data, req);
  endtask

  task automatic op(input int opc, input int a, input int b, input string req);
    step(1, mk(opc, a, b), 0, 32'h0, req);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 0; instr_valid = 0; instr_word = 0; mem_rvalid = 0; mem_rdata = 0;
    for (int i = 0; i < 8; i++) m_reg[i] = 0;
    m_z = 0; m_c = 0; m_n = 0; m_halt = 0; m_wait = 0; m_dst = 0; m_sp = 24'hFFFFF0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    idle("R13");
    // R13: registers read back as zero through a store at address R0=0
    op(8, 5, 0, "R13");

    // R7: seed registers via loads at address held in R0, varied response gaps
    rd_op(mk(9, 0, 1), 32'h7FFF_FFFF, 0, "R7");
    rd_op(mk(9, 0, 2), 32'h0000_0001, 1, "R7");
    rd_op(mk(9, 0, 3), 32'h00FF_FFFC, 2, "R7");
    rd_op(mk(9, 0, 4), 32'h01FF_FFFC, 0, "R7");
    rd_op(mk(9, 0, 5), 32'h8000_0001, 3, "R7");
    rd_op(mk(9, 0, 6), 32'h0000_0010, 0, "R7");
    rd_op(mk(9, 0, 7), 32'hA5A5_0003, 1, "R7");
    // R1: operand fields use low three bits (0x09 -> R1, 0x0A -> R2)
    op(8, 9, 10, "R1");

    op(0, 1, 2, "R2");  // 0x7FFFFFFF+1: N set, no carry
    op(0, 5, 5, "R2");  // carry out
    op(1, 2, 2, "R2");  // zero
    op(1, 2, 6, "R2");  // borrow
    op(2, 1, 0, "R3");  // 0x80000000 << 1: carry, zero
    op(3, 7, 0, "R3");  // odd >> 1: carry
    op(2, 7, 0, "R3");
    op(4, 6, 6, "R4");  // compare equal
    op(4, 2, 6, "R4");
    op(8, 6, 0, "R4");  // R6 unchanged
    op(8, 2, 0, "R2");

    // R5: moves, push, halt-free ops keep flags
    op(8, 7, 6, "R6");
    op(8, 5, 3, "R8");  // terminal
    op(8, 1, 4, "R8");  // masked, no strobe
    rd_op(mk(9, 3, 0), 32'h1234_5678, 2, "R7");
    op(8, 0, 6, "R7");

    // R9/R10: stack
    op(6, 6, 0, "R9");
    op(6, 0, 0, "R9");
    rd_op(mk(7, 4, 0), 32'hCAFE_0001, 1, "R10");
    rd_op(mk(7, 5, 0), 32'h0000_0000, 0, "R10");
    op(6, 4, 0, "R10");
    op(8, 5, 6, "R10");

    // R11: illegal words
    step(1, 32'h4000_0000, 0, 32'h0, "R11");
    op(10, 1, 2, "R11");
    op(13'h1FFF, 1, 2, "R11");
    step(1, 32'h0001_0102, 0, 32'h0, "R11");
    op(8, 1, 0, "R11");

    // R12: halt, then everything is ignored
    op(5, 0, 0, "R12");
    op(8, 1, 3, "R12");
    op(0, 1, 1, "R12");
    op(9, 0, 1, "R12");
    step(1, 32'hFFFF_FFFF, 0, 32'h0, "R12");
    idle("R12");
    summary();
  end
endmodule